// File: doc/BRIEF.md
# Variable-Length Packet Line Builder

This block sits between a memory that delivers fixed-width lines and a downstream aligner that expects one data packet at a time. The lines carry variable-length packets packed end to end with no padding, so a packet may start anywhere inside a line and may run into the next line. Each packet opens with a small header field. Its code picks the payload length from a table that is set at elaboration time, so each algorithm variant builds its own table.

The block keeps a small cache of whole memory lines. From the current bit offset it reads the header of the next packet and works out how far the packet reaches and how many lines it covers. Once every one of those lines is in the cache, it registers an extended line made of the cached lines, together with the bit offset, the line count and the header code. The aligner only has to shift the extended line right by the offset. The lines that the packet used up are then dropped from the cache, and the offset moves on to the bit that follows the packet. Both sides use valid/ready handshakes, and the block can deliver one packet per cycle.

Top module: `vlp_line_builder`

## Requirements
- R1: A packet's first HDR_W bits are its header code, and its total length is HDR_W plus PAY_LEN[code]. With the defaults (HDR_W = 2, PAY_LEN = 6, 14, 30, 45 for codes 0 to 3) the totals are 8, 16, 32 and 47 bits, and `out_code` carries the code.
- R2: Bit k of the stream is bit k mod LINE_W of input line k / LINE_W, with lines in arrival order. For each packet, `out_shift` equals the stream position of its first bit, mod LINE_W. Each packet starts at the bit right after the previous one, and the first packet after reset starts at bit 0.
- R3: `out_lines` equals ceil((out_shift + total length) / LINE_W).
- R4: The packet's bits, header in the low bits followed by the payload, sit at `out_data[out_shift +: length]`. Cached line 0 occupies the low LINE_W bits of `out_data`.
- R5: Packets come out in stream order, each exactly once.
- R6: While any line that a packet touches has not yet been accepted, `out_valid` stays low for that packet.
- R7: While `out_valid` is high and `out_ready` is low, every output field holds its value and `out_valid` stays high.
- R8: Synchronous active-high reset empties the cache, sets the offset to 0 and clears `out_valid`. After reset `in_ready` is high.
- R9: With `in_valid` and `out_ready` held high, consecutive packets are transferred on consecutive cycles.
- R10: Backpressure reaches the input. With `out_ready` held low and a steady supply of lines, the block accepts lines only until its cache of LINES lines (3 by default) is full, and then holds `in_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Memory line offered |
| in_ready | output | 1 | Line will be accepted this cycle |
| in_data | input | LINE_W | Memory line |
| out_valid | output | 1 | Extended line holds a complete packet |
| out_ready | input | 1 | Downstream takes the packet |
| out_data | output | LINES*LINE_W | Extended line, cached line 0 in the low bits |
| out_shift | output | log2(LINE_W) | Bit offset of the packet inside `out_data` |
| out_lines | output | clog2(LINES+1) | Number of lines the packet covers |
| out_code | output | HDR_W | Header code of the packet |

## Verification
A line accepted at one clock edge is available to the header decoder in the next cycle. A packet whose last line enters at edge t therefore reaches the output register at edge t+1 and is visible from then on. `in_ready` depends combinationally on `out_ready` in the same cycle. The bench drives and samples in the second half of each period, after everything has settled, and treats a transfer as occurring at the next rising edge. Each result is compared with the packet that the bench expects next in order, not with a fixed cycle count, so checks remain correct under throttled input and output. Only the throughput and backpressure checks count cycles, and they count from the first transfer or from the start of the stall.

// File: rtl/vlp_pkg.sv
package vlp_pkg;

    localparam int DEF_LINE_W = 32;
    localparam int DEF_HDR_W  = 2;
    localparam int PL_W       = 8;   // width of one payload-length table entry
    localparam int MAX_CODES  = 16;  // header codes supported by max_entry()

    typedef enum logic [1:0] {
        DEC_NO_HDR,   // header bits not all cached yet
        DEC_SHORT,    // header known, packet tail missing
        DEC_GO        // whole packet cached
    } dec_status_e;

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int max_entry(input logic [MAX_CODES*PL_W-1:0] flat, input int n);
        int m;
        m = 0;
        for (int i = 0; i < n; i++) begin
            if (int'(flat[i*PL_W +: PL_W]) > m) m = int'(flat[i*PL_W +: PL_W]);
        end
        return m;
    endfunction

endpackage

// File: rtl/vlp_hdr_decode.sv
module vlp_hdr_decode
    import vlp_pkg::*;
#(
    parameter int LINE_W = DEF_LINE_W,
    parameter int HDR_W  = DEF_HDR_W,
    parameter int LINES  = 3,
    parameter logic [(1<<HDR_W)-1:0][PL_W-1:0] PAY_LEN = '0,
    localparam int EXT_W = LINES * LINE_W,
    localparam int OFF_W = $clog2(LINE_W),
    localparam int CNT_W = $clog2(LINES + 1),
    localparam int SUM_W = $clog2(EXT_W + 1) + 1
) (
    input  logic [EXT_W-1:0] window,
    input  logic [OFF_W-1:0] off,
    input  logic [CNT_W-1:0] cnt,
    output dec_status_e      status,
    output logic [HDR_W-1:0] code,
    output logic [CNT_W-1:0] need,
    output logic [CNT_W-1:0] drop,
    output logic [OFF_W-1:0] nxt_off
);

    logic [HDR_W-1:0] raw_hdr;
    logic [SUM_W-1:0] tot_len;
    logic [SUM_W-1:0] end_pos;
    logic [CNT_W-1:0] hdr_need;

    assign raw_hdr = HDR_W'(window >> off);
    assign code    = raw_hdr;

    always_comb begin
        tot_len  = SUM_W'(HDR_W) + SUM_W'(PAY_LEN[raw_hdr]);
        end_pos  = SUM_W'(off) + tot_len;
        // LINE_W is a power of two: division by shifting
        need     = CNT_W'((end_pos + SUM_W'(LINE_W - 1)) >> OFF_W);
        drop     = CNT_W'(end_pos >> OFF_W);
        nxt_off  = end_pos[OFF_W-1:0];
        hdr_need = CNT_W'((SUM_W'(off) + SUM_W'(HDR_W + LINE_W - 1)) >> OFF_W);
        if (cnt < hdr_need)  status = DEC_NO_HDR;
        else if (cnt < need) status = DEC_SHORT;
        else                 status = DEC_GO;
    end

endmodule

// File: rtl/vlp_line_cache.sv
module vlp_line_cache
    import vlp_pkg::*;
#(
    parameter int LINE_W = DEF_LINE_W,
    parameter int LINES  = 3,
    localparam int EXT_W = LINES * LINE_W,
    localparam int OFF_W = $clog2(LINE_W),
    localparam int CNT_W = $clog2(LINES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [LINE_W-1:0] in_data,
    output logic              in_ready,
    input  logic              take,
    input  logic [CNT_W-1:0]  drop,
    input  logic [OFF_W-1:0]  nxt_off,
    output logic [EXT_W-1:0]  window,
    output logic [OFF_W-1:0]  off,
    output logic [CNT_W-1:0]  cnt
);

    logic [LINES-1:0][LINE_W-1:0] lines_q;
    logic [LINE_W-1:0]            lines_d [LINES];
    logic [EXT_W-1:0]             shifted;
    logic [CNT_W-1:0]             cnt_q;
    logic [CNT_W-1:0]             drop_eff;
    logic [CNT_W-1:0]             left;
    logic [OFF_W-1:0]             off_q;
    logic                         accept;

    always_comb begin
        drop_eff = take ? drop : '0;
        left     = cnt_q - drop_eff;
        in_ready = left < CNT_W'(LINES);
        accept   = in_valid && in_ready;
    end

    assign shifted = lines_q >> (LINE_W * int'(drop_eff));

    for (genvar g = 0; g < LINES; g++) begin : g_slot
        always_comb begin
            lines_d[g] = (accept && (int'(left) == g)) ? in_data
                                                        : shifted[g*LINE_W +: LINE_W];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) lines_q[i] <= lines_d[i];
        if (rst) begin
            cnt_q <= '0;
            off_q <= '0;
        end else begin
            cnt_q <= left + CNT_W'(accept);
            if (take) off_q <= nxt_off;
        end
    end

    assign window = lines_q;
    assign off    = off_q;
    assign cnt    = cnt_q;

endmodule

// File: rtl/vlp_line_builder.sv
module vlp_line_builder
    import vlp_pkg::*;
#(
    parameter int LINE_W = DEF_LINE_W,
    parameter int HDR_W  = DEF_HDR_W,
    parameter logic [(1<<HDR_W)-1:0][PL_W-1:0] PAY_LEN = {8'd45, 8'd30, 8'd14, 8'd6},
    localparam int NUM_CODES = 1 << HDR_W,
    localparam int MAX_LEN   = HDR_W + max_entry((MAX_CODES*PL_W)'(PAY_LEN), NUM_CODES),
    localparam int LINES     = cdiv(LINE_W + MAX_LEN - 1, LINE_W),
    localparam int EXT_W     = LINES * LINE_W,
    localparam int OFF_W     = $clog2(LINE_W),
    localparam int CNT_W     = $clog2(LINES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [LINE_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [EXT_W-1:0]  out_data,
    output logic [OFF_W-1:0]  out_shift,
    output logic [CNT_W-1:0]  out_lines,
    output logic [HDR_W-1:0]  out_code
);

    typedef struct packed {
        logic [EXT_W-1:0] data;
        logic [OFF_W-1:0] shift;
        logic [CNT_W-1:0] lines;
        logic [HDR_W-1:0] code;
    } ext_pkt_t;

    logic [EXT_W-1:0] window;
    logic [OFF_W-1:0] off;
    logic [CNT_W-1:0] cnt;
    dec_status_e      status;
    logic [HDR_W-1:0] code;
    logic [CNT_W-1:0] need;
    logic [CNT_W-1:0] drop;
    logic [OFF_W-1:0] nxt_off;
    logic             fire;
    logic             ov_q;
    ext_pkt_t         pkt_q;

    vlp_line_cache #(
        .LINE_W (LINE_W),
        .LINES  (LINES)
    ) u_cache (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .take     (fire),
        .drop     (drop),
        .nxt_off  (nxt_off),
        .window   (window),
        .off      (off),
        .cnt      (cnt)
    );

    vlp_hdr_decode #(
        .LINE_W  (LINE_W),
        .HDR_W   (HDR_W),
        .LINES   (LINES),
        .PAY_LEN (PAY_LEN)
    ) u_dec (
        .window  (window),
        .off     (off),
        .cnt     (cnt),
        .status  (status),
        .code    (code),
        .need    (need),
        .drop    (drop),
        .nxt_off (nxt_off)
    );

    assign fire = (status == DEC_GO) && (!ov_q || out_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            ov_q <= 1'b0;
        end else if (fire) begin
            ov_q        <= 1'b1;
            pkt_q.data  <= window;
            pkt_q.shift <= off;
            pkt_q.lines <= need;
            pkt_q.code  <= code;
        end else if (out_ready) begin
            ov_q <= 1'b0;
        end
    end

    assign out_valid = ov_q;
    assign out_data  = pkt_q.data;
    assign out_shift = pkt_q.shift;
    assign out_lines = pkt_q.lines;
    assign out_code  = pkt_q.code;

endmodule

// File: rtl/vlp_line_builder_chk.sv
module vlp_line_builder_chk
    import vlp_pkg::*;
#(
    parameter int LINE_W = DEF_LINE_W,
    parameter int HDR_W  = DEF_HDR_W,
    parameter logic [(1<<HDR_W)-1:0][PL_W-1:0] PAY_LEN = {8'd45, 8'd30, 8'd14, 8'd6},
    localparam int NUM_CODES = 1 << HDR_W,
    localparam int MAX_LEN   = HDR_W + max_entry((MAX_CODES*PL_W)'(PAY_LEN), NUM_CODES),
    localparam int LINES     = cdiv(LINE_W + MAX_LEN - 1, LINE_W),
    localparam int EXT_W     = LINES * LINE_W,
    localparam int OFF_W     = $clog2(LINE_W),
    localparam int CNT_W     = $clog2(LINES + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [LINE_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [EXT_W-1:0]  out_data,
    input logic [OFF_W-1:0]  out_shift,
    input logic [CNT_W-1:0]  out_lines,
    input logic [HDR_W-1:0]  out_code
);

    logic             rst_q;
    logic             have_exp;
    logic [OFF_W-1:0] exp_shift;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            have_exp <= 1'b0;
        end else if (out_valid && out_ready) begin
            have_exp  <= 1'b1;
            exp_shift <= OFF_W'((int'(out_shift) + HDR_W + int'(PAY_LEN[out_code])) % LINE_W);
        end
    end

    // R8: the cycle after a reset edge shows no packet
    always_ff @(posedge clk) begin
        if (rst_q) a_r8_reset_idle: assert (!out_valid);
    end

    // R7: a stalled packet is held unchanged
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_shift)
                                    && $stable(out_lines) && $stable(out_code));

    // R3: line count covers offset plus packet length
    a_r3_lines_cover: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> int'(out_lines) == cdiv(int'(out_shift) + HDR_W + int'(PAY_LEN[out_code]), LINE_W));

    // R2: each packet starts where the previous transferred one ended
    a_r2_next_shift: assert property (@(posedge clk) disable iff (rst)
        out_valid && have_exp |-> out_shift == exp_shift);

    // R10: the input side never claims room while the handshake signals are unknown
    a_r10_ready_known: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> !$isunknown(in_ready));

    logic unused_ok;
    assign unused_ok = ^{in_data, 1'b0};

endmodule

bind vlp_line_builder vlp_line_builder_chk #(
    .LINE_W  (LINE_W),
    .HDR_W   (HDR_W),
    .PAY_LEN (PAY_LEN)
) u_chk (.*);

// File: tb/test_vlp_line_builder.sv
`timescale 1ns/1ps
module test_vlp_line_builder;

    localparam int LW   = 32;
    localparam int EXTW = 96;
    localparam int NV   = 12;
    localparam logic [1:0]  V_CODE [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd3, 2'd0,
                                            2'd2, 2'd1, 2'd3, 2'd0, 2'd0, 2'd2};
    localparam logic [47:0] V_PAY  [NV] = '{48'h2B, 48'h1A5C, 48'h2345_6789, 48'h1FFF_FFFF_FFFF,
                                            48'h0, 48'h3F, 48'h1, 48'h2000,
                                            48'h1555_5555_5555, 48'h15, 48'h2A, 48'h3FFF_FFFF};

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid;
    logic            in_ready;
    logic [LW-1:0]   in_data;
    logic            out_valid;
    logic            out_ready;
    logic [EXTW-1:0] out_data;
    logic [4:0]      out_shift;
    logic [1:0]      out_lines;
    logic [1:0]      out_code;

    always #4 clk = ~clk;

    vlp_line_builder i_vlp_line_builder (
        .clk (clk), .rst (rst),
        .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
        .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data),
        .out_shift (out_shift), .out_lines (out_lines), .out_code (out_code)
    );

    int n_tests = 0;
    int n_fail  = 0;

    int          np;
    int          nl;
    int          pk_code [32];
    logic [63:0] pk_bits [32];
    int          pk_pos  [32];
    logic [1023:0] stream;
    int first_t, last_t, acc_stall;

    function automatic int plen(input int c);
        case (c)
            0: return 8;
            1: return 16;
            2: return 32;
            default: return 47;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic add_pkt(input int c, input logic [47:0] pay);
        logic [63:0] m;
        int L;
        L = plen(c);
        m = (64'd1 << L) - 64'd1;
        pk_code[np] = c;
        pk_bits[np] = ({16'd0, pay} << 2 | 64'(c)) & m;
        np++;
    endtask

    task automatic build();
        int p;
        stream = '0;
        p = 0;
        for (int k = 0; k < np; k++) begin
            pk_pos[k] = p;
            for (int b = 0; b < plen(pk_code[k]); b++) stream[p + b] = pk_bits[k][b];
            p += plen(pk_code[k]);
        end
        nl = (p + LW - 1) / LW;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R8", "out_valid after reset", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R8", "in_ready after reset", 64'(in_ready), 64'd1);
    endtask

    // rmode: 0 ready always, 1 ready pattern, 2 ready low for 20 cycles
    // gmode: 0 input always, 1 input pattern, 2 hold after first line for 8 cycles
    task automatic run_stream(input int rmode, input int gmode);
        int li, ng, cyc, stall_cnt, sh, L, ln;
        bit gate, prev_stall;
        logic [EXTW-1:0] pd, tmp;
        logic [4:0] ps;
        logic [1:0] pl, pc;
        logic [63:0] got, m;
        li = 0; ng = 0; cyc = 0; stall_cnt = 0; prev_stall = 0;
        first_t = -1; last_t = -1; acc_stall = 0;
        pd = '0; ps = '0; pl = '0; pc = '0;
        while (ng < np && cyc < 3000) begin
            @(negedge clk);
            case (rmode)
                0: out_ready = 1'b1;
                1: out_ready = (cyc % 3) != 2;
                default: out_ready = cyc >= 20;
            endcase
            case (gmode)
                0: gate = 1'b1;
                1: gate = (cyc % 4) != 3;
                default: gate = !(li == 1 && stall_cnt < 8);
            endcase
            in_valid = (li < nl) && gate;
            in_data  = stream[li*LW +: LW];
            #1;
            if (prev_stall) begin
                chk(out_valid && out_data == pd && out_shift == ps && out_lines == pl && out_code == pc,
                    "R7", "held packet", 64'(out_shift), 64'(ps));
            end
            if (gmode == 2 && li == 1 && stall_cnt < 8) begin
                chk(out_valid == 1'b0, "R6", "valid with missing line", 64'(out_valid), 64'd0);
                stall_cnt++;
            end
            if (out_valid && out_ready) begin
                L  = plen(pk_code[ng]);
                sh = pk_pos[ng] % LW;
                ln = (sh + L + LW - 1) / LW;
                m  = (64'd1 << L) - 64'd1;
                tmp = out_data >> out_shift;
                got = tmp[63:0] & m;
                chk(int'(out_code) == pk_code[ng], "R1", "code", 64'(out_code), 64'(pk_code[ng]));
                chk(int'(out_shift) == sh, "R2", "shift", 64'(out_shift), 64'(sh));
                chk(int'(out_lines) == ln, "R3", "lines", 64'(out_lines), 64'(ln));
                chk(got == pk_bits[ng], "R4", "packet bits", got, pk_bits[ng]);
                if (first_t < 0) first_t = cyc;
                last_t = cyc;
                ng++;
            end
            prev_stall = out_valid && !out_ready;
            pd = out_data; ps = out_shift; pl = out_lines; pc = out_code;
            if (in_valid && in_ready) begin
                li++;
                if (rmode == 2 && cyc < 20) acc_stall++;
            end
            cyc++;
        end
        chk(ng == np, "R5", "packets delivered in order", 64'(ng), 64'(np));
        @(negedge clk);
        in_valid = 1'b0;
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; in_data = '0;

        // table walk: mixed lengths, throttled on both sides (R1-R5, R7)
        np = 0;
        for (int k = 0; k < NV; k++) add_pkt(int'(V_CODE[k]), V_PAY[k]);
        build();
        do_reset();
        run_stream(1, 1);

        // reset while the cache and output hold leftovers (R8), then R10 stall
        do_reset();
        run_stream(2, 0);
        chk(acc_stall == 3, "R10", "lines accepted under stall", 64'(acc_stall), 64'd3);

        // sustained rate with short packets (R9)
        np = 0;
        for (int k = 0; k < 16; k++) add_pkt(0, 48'(k * 5 + 3));
        build();
        do_reset();
        run_stream(0, 0);
        chk(last_t - first_t == np - 1, "R9", "cycles first to last transfer",
            64'(last_t - first_t), 64'(np - 1));

        // packet straddling two lines, second line withheld (R6)
        np = 0;
        add_pkt(3, 48'h0ABC_DEF0_1234);
        add_pkt(1, 48'h0777);
        build();
        do_reset();
        run_stream(0, 2);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule